// File: doc/BRIEF.md
# Pipeline Operand Forwarding Selector

This block builds the two ALU source operands of a simple in-order pipeline and holds them in operand registers A and B. For each source register number presented in the decode cycle, it chooses one of four values: the constant zero, the result now leaving the execute stage, the result now leaving the memory stage, or the register file. The selection sits in front of the operand registers. The loop therefore runs from A/B through the external ALU and its result mux, and back into A/B through this selector. The execute-stage result input carries whatever that stage's result mux produced, so a link address from a jump-and-link is forwarded in the same way as an ALU sum.

The block contains the register file, with two read ports and one write port. The write port is driven by the write-back stage. A read of a register that is being written in the same cycle returns the new value. Register 0 reads as zero and cannot be changed. An all-zero instruction word is an add of r0 to r0 into r0 with no write enabled. Its fields therefore yield zero operands and leave every register unchanged.

Top module: `operand_fwd`

## Requirements
- R1: While rst_ni is low, opa_o and opb_o are zero and every register file entry is cleared to zero.
- R2: On each rising clock edge, opa_o and opb_o take the operand selected for src1_i and src2_i as they stood before that edge, giving one cycle of latency.
- R3: A nonzero source number equal to ex_rd_i with ex_we_i high selects ex_data_i.
- R4: A nonzero source number equal to mem_rd_i with mem_we_i high, and with no execute-stage match, selects mem_data_i.
- R5: When both the execute and memory stages match a source, the execute-stage (younger) result wins.
- R6: With no stage match, the operand is the register file value. A write-back to that same register in the same cycle (wb_we_i high, wb_rd_i equal) supplies wb_data_i (write before read).
- R7: Source number 0 always yields zero, even when a stage with its write enable set names r0 as destination.
- R8: A write-back to register 0 has no effect. Later reads of r0 still return zero.
- R9: A stage whose write enable is low is never forwarded from. A write-back with wb_we_i low changes no register.
- R10: A cycle whose fields are all zero (the NOP encoding: sources 0, destinations 0, enables 0) produces zero operands and leaves all registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src1_i | input | 5 | Source register number for operand A |
| src2_i | input | 5 | Source register number for operand B |
| ex_rd_i | input | 5 | Destination of the instruction in execute |
| ex_we_i | input | 1 | Execute-stage register write enable |
| ex_data_i | input | 32 | Execute-stage result |
| mem_rd_i | input | 5 | Destination of the instruction in the memory stage |
| mem_we_i | input | 1 | Memory-stage register write enable |
| mem_data_i | input | 32 | Memory-stage result |
| wb_rd_i | input | 5 | Write-back destination register |
| wb_we_i | input | 1 | Write-back enable |
| wb_data_i | input | 32 | Write-back data |
| opa_o | output | 32 | Operand register A |
| opb_o | output | 32 | Operand register B |

## Verification
Assertions check the following properties on every clock edge: a zero source always latches zero, an execute-stage match latches that stage's data ahead of any memory-stage match, and a memory-only match latches the memory data. A further assertion checks that a same-cycle write-back appears on the register file's read port. Register contents can only be seen through later reads, so the bench's scenarios are needed to show several behaviours. These are that writes to r0 or with the enable low leave nothing behind, that an all-zero NOP stream preserves every register, and that reset clears the whole file. The bench's reference model also covers long random streams, where destination collisions among the stages are frequent.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_EX   = 2'd1,
    SRC_MEM  = 2'd2,
    SRC_RF   = 2'd3
  } fwd_src_e;
endpackage

// File: rtl/fwd_regfile.sv
module fwd_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  parameter int NRD   = 2,
  localparam int RIDX = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [RIDX-1:0] wa_i,
  input  logic [XLEN-1:0] wd_i,
  input  logic [RIDX-1:0] ra_i [NRD],
  output logic [XLEN-1:0] rd_o [NRD]
);
  logic [XLEN-1:0] mem_q [NREGS];
  logic            wr_ok;

  assign wr_ok = we_i && (wa_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) mem_q[i] <= '0;
    end else if (wr_ok) begin
      mem_q[wa_i] <= wd_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    // write before read: same-cycle write visible
    always_comb begin
      if (ra_i[p] == '0)                rd_o[p] = '0;
      else if (wr_ok && wa_i == ra_i[p]) rd_o[p] = wd_i;
      else                               rd_o[p] = mem_q[ra_i[p]];
    end

    a_r6_wb_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && wa_i != '0 && wa_i == ra_i[p]) |-> (rd_o[p] == wd_i));
  end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
  import fwd_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input  logic [RIDX-1:0] src_i,
  input  logic [RIDX-1:0] ex_rd_i,
  input  logic            ex_we_i,
  input  logic [XLEN-1:0] ex_data_i,
  input  logic [RIDX-1:0] mem_rd_i,
  input  logic            mem_we_i,
  input  logic [XLEN-1:0] mem_data_i,
  input  logic [XLEN-1:0] rf_data_i,
  output fwd_src_e        sel_o,
  output logic [XLEN-1:0] op_o
);
  logic hit_ex, hit_mem;

  assign hit_ex  = ex_we_i  && (ex_rd_i  == src_i);
  assign hit_mem = mem_we_i && (mem_rd_i == src_i);

  // r0 first, then younger stage first
  always_comb begin
    if (src_i == '0)  sel_o = SRC_ZERO;
    else if (hit_ex)  sel_o = SRC_EX;
    else if (hit_mem) sel_o = SRC_MEM;
    else              sel_o = SRC_RF;
  end

  always_comb begin
    unique case (sel_o)
      SRC_ZERO: op_o = '0;
      SRC_EX:   op_o = ex_data_i;
      SRC_MEM:  op_o = mem_data_i;
      default:  op_o = rf_data_i;
    endcase
  end
endmodule

// File: rtl/operand_fwd.sv
module operand_fwd
  import fwd_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int RIDX = $clog2(NREGS),
  localparam int NOPS = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RIDX-1:0] src1_i,
  input  logic [RIDX-1:0] src2_i,
  input  logic [RIDX-1:0] ex_rd_i,
  input  logic            ex_we_i,
  input  logic [XLEN-1:0] ex_data_i,
  input  logic [RIDX-1:0] mem_rd_i,
  input  logic            mem_we_i,
  input  logic [XLEN-1:0] mem_data_i,
  input  logic [RIDX-1:0] wb_rd_i,
  input  logic            wb_we_i,
  input  logic [XLEN-1:0] wb_data_i,
  output logic [XLEN-1:0] opa_o,
  output logic [XLEN-1:0] opb_o
);
  logic [RIDX-1:0] src_w  [NOPS];
  logic [XLEN-1:0] rf_w   [NOPS];
  logic [XLEN-1:0] nxt_w  [NOPS];
  logic [XLEN-1:0] op_q   [NOPS];
  fwd_src_e        sel_w  [NOPS];

  assign src_w[0] = src1_i;
  assign src_w[1] = src2_i;

  fwd_regfile #(.XLEN(XLEN), .NREGS(NREGS), .NRD(NOPS)) u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (wb_we_i),
    .wa_i  (wb_rd_i),
    .wd_i  (wb_data_i),
    .ra_i  (src_w),
    .rd_o  (rf_w)
  );

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    fwd_mux #(.XLEN(XLEN), .RIDX(RIDX)) u_mux (
      .src_i     (src_w[k]),
      .ex_rd_i   (ex_rd_i),
      .ex_we_i   (ex_we_i),
      .ex_data_i (ex_data_i),
      .mem_rd_i  (mem_rd_i),
      .mem_we_i  (mem_we_i),
      .mem_data_i(mem_data_i),
      .rf_data_i (rf_w[k]),
      .sel_o     (sel_w[k]),
      .op_o      (nxt_w[k])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) op_q[k] <= '0;
      else         op_q[k] <= nxt_w[k];
    end

    a_r7_zero_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_w[k] == '0) |=> (op_q[k] == '0));

    a_r5_ex_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_w[k] != '0 && ex_we_i && ex_rd_i == src_w[k])
      |=> (op_q[k] == $past(ex_data_i)));

    a_r4_mem_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_w[k] != '0 && !(ex_we_i && ex_rd_i == src_w[k])
       && mem_we_i && mem_rd_i == src_w[k])
      |=> (op_q[k] == $past(mem_data_i)));
  end

  assign opa_o = op_q[0];
  assign opb_o = op_q[1];
endmodule

// File: tb/operand_fwd_test.sv
module operand_fwd_test;
  localparam int XLEN = 32;
  localparam int RIDX = 5;

  logic            clk = 0;
  logic            rst_n = 0;
  logic [RIDX-1:0] src1 = 0, src2 = 0, ex_rd = 0, mem_rd = 0, wb_rd = 0;
  logic            ex_we = 0, mem_we = 0, wb_we = 0;
  logic [XLEN-1:0] ex_d = 0, mem_d = 0, wb_d = 0;
  logic [XLEN-1:0] opa, opb;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [XLEN-1:0] model [32];

  always #4 clk = ~clk;

  operand_fwd uut (
    .clk_i(clk), .rst_ni(rst_n),
    .src1_i(src1), .src2_i(src2),
    .ex_rd_i(ex_rd), .ex_we_i(ex_we), .ex_data_i(ex_d),
    .mem_rd_i(mem_rd), .mem_we_i(mem_we), .mem_data_i(mem_d),
    .wb_rd_i(wb_rd), .wb_we_i(wb_we), .wb_data_i(wb_d),
    .opa_o(opa), .opb_o(opb)
  );

  function automatic logic [XLEN-1:0] ref_op(int s);
    if (s == 0) return '0;
    if (ex_we && ex_rd == s) return ex_d;
    if (mem_we && mem_rd == s) return mem_d;
    if (wb_we && wb_rd == s) return wb_d;
    return model[s];
  endfunction

  task automatic chk(string req, logic [XLEN-1:0] got, logic [XLEN-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // inputs already set at negedge; compute, clock, compare
  task automatic step(string req);
    logic [XLEN-1:0] ea, eb;
    ea = ref_op(src1);
    eb = ref_op(src2);
    if (wb_we && wb_rd != 0) model[wb_rd] = wb_d;
    @(posedge clk); #2;
    chk({req, " opa"}, opa, ea);
    chk({req, " opb"}, opb, eb);
    @(negedge clk);
  endtask

  task automatic idle();
    src1 = 0; src2 = 0; ex_rd = 0; ex_we = 0; ex_d = 0;
    mem_rd = 0; mem_we = 0; mem_d = 0; wb_rd = 0; wb_we = 0; wb_d = 0;
  endtask

  task automatic rd_all(string req);
    idle();
    for (int i = 0; i < 32; i += 2) begin
      src1 = i[4:0]; src2 = 5'(i + 1);
      step(req);
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    #20;
    chk("R1 reset opa", opa, '0);
    chk("R1 reset opb", opb, '0);
    @(negedge clk); rst_n = 1;
    rd_all("R1 cleared file");

    // fill registers through write-back
    for (int i = 1; i < 32; i++) begin
      idle(); wb_we = 1; wb_rd = i[4:0]; wb_d = 32'hA500_0000 + i;
      step("R6 fill");
    end
    rd_all("R6 regfile read");

    // same-cycle write before read
    idle(); wb_we = 1; wb_rd = 5; wb_d = 32'h1234_5678; src1 = 5; src2 = 6;
    step("R6 wb bypass");

    // EX forward
    idle(); ex_we = 1; ex_rd = 7; ex_d = 32'hE0E0_0007; src1 = 7; src2 = 8;
    step("R3 ex fwd");
    // MEM forward
    idle(); mem_we = 1; mem_rd = 9; mem_d = 32'h3E30_0009; src1 = 10; src2 = 9;
    step("R4 mem fwd");
    // both match: EX wins, wb also matching
    idle(); ex_we = 1; ex_rd = 11; ex_d = 32'h0000_EEEE;
    mem_we = 1; mem_rd = 11; mem_d = 32'h0000_3333;
    wb_we = 1; wb_rd = 11; wb_d = 32'h0000_BBBB; src1 = 11; src2 = 11;
    step("R5 ex priority");
    // MEM over WB
    idle(); mem_we = 1; mem_rd = 12; mem_d = 32'h3333_0012;
    wb_we = 1; wb_rd = 12; wb_d = 32'hBBBB_0012; src1 = 12; src2 = 13;
    step("R4 mem over wb");
    // enables low
    idle(); ex_rd = 14; ex_d = 32'hDEAD_0001; mem_rd = 15; mem_d = 32'hDEAD_0002;
    wb_rd = 16; wb_d = 32'hDEAD_0003; src1 = 14; src2 = 15;
    step("R9 no fwd when disabled");
    idle(); src1 = 16; src2 = 14;
    step("R9 no write when disabled");
    // r0
    idle(); ex_we = 1; ex_rd = 0; ex_d = 32'hFFFF_FFFF;
    mem_we = 1; mem_rd = 0; mem_d = 32'hFFFF_FFFE; src1 = 0; src2 = 0;
    step("R7 r0 never forwarded");
    idle(); wb_we = 1; wb_rd = 0; wb_d = 32'hFFFF_0000; src1 = 0; src2 = 1;
    step("R8 r0 write same cycle");
    idle(); src1 = 0; src2 = 0;
    step("R8 r0 after write");
    // NOP stream
    idle();
    for (int i = 0; i < 6; i++) step("R10 nop operands");
    rd_all("R10 nop preserves file");

    // random stream with dense collisions
    for (int n = 0; n < 3000; n++) begin
      src1 = 5'($urandom_range(0, 5)); src2 = 5'($urandom_range(0, 5));
      ex_rd = 5'($urandom_range(0, 5)); ex_we = 1'($urandom); ex_d = $urandom;
      mem_rd = 5'($urandom_range(0, 5)); mem_we = 1'($urandom); mem_d = $urandom;
      wb_rd = 5'($urandom_range(0, 5)); wb_we = 1'($urandom); wb_d = $urandom;
      step("R2 random stream");
    end
    rd_all("R2 final file");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule